// File: doc/BRIEF.md
# NAND Flash Bus Interface Controller

This block connects a simple CPU register port to an asynchronous NAND flash bus. Software sets the latch lines, the chip select and the chip enable through a mode register. It then moves bytes by writing or reading a data register. Every data access becomes one strobe cycle on the flash bus: a low pulse on the write or read strobe, then a hold interval. During the hold interval written data stays on the bus.

Two 4-bit fields of a timing register set the strobe width and the hold length in bus clocks. The strobe width is the field value plus one clock, and the hold is the field value plus two clocks. The CPU port drops `cpu_ready` while a strobe cycle is running, so a new access waits until the flash bus is idle. This means the latch and select pins can never change in the middle of a strobe.

A status register shows the synchronized flash busy line. A self-clearing reset register returns the controller to its power-up settings.

Top module: `nand_bus_ctrl`

## Requirements
- R1: After `rst`, every `nand_ce_n` line is high, `nand_cle`, `nand_ale` and `nand_dq_oe` are low, both strobes are high, `cpu_ready` is high, the mode register reads 0x00 and the timing register reads 0xFF.
- R2: Mode register (offset 0x04) drives the flash lines from the clock edge that accepts the write:
  - bit 0 drives `nand_cle`;
  - bit 1 drives `nand_ale`;
  - bits 3:2 select which `nand_ce_n` line is used;
  - bit 4 has inverted sense: 1 drives the selected `nand_ce_n` low and 0 leaves it high;
  - unselected lines stay high;
  - bits 6:5 read back as zero.
- R3: A write to the data register (offset 0x00) while mode bit 7 is 1 does the following:
  - it drives `cpu_wdata` on `nand_dq_o` with `nand_dq_oe` high;
  - it holds `nand_we_n` low for SPW+1 clocks;
  - it then keeps the data driven for HOLD+2 clocks with `nand_we_n` high;
  - after that `nand_dq_oe` falls and `cpu_ready` rises.
- R4: A data register write while mode bit 7 is 0 is ignored: `nand_we_n` stays high, `nand_dq_oe` stays low and `cpu_ready` stays high.
- R5: A data register read does the following:
  - it holds `nand_re_n` low for SPW+1 clocks;
  - it captures `nand_dq_i` in the last low clock;
  - after HOLD+2 further clocks it returns that byte on `cpu_rdata` with `cpu_rvalid` high, in the same cycle in which `cpu_ready` rises.
  - A change on `nand_dq_i` after the strobe does not alter the returned byte.
- R6: The timing register (offset 0x14) holds HOLD in bits 7:4 and SPW in bits 3:0, and reads back as written.
- R7: Status register (offset 0x08) bit 7 reads 1 while `nand_rb_n` is low, after a two-flop synchronizer. The other bits read 0.
- R8: Writing 1 to bit 0 of the reset register (offset 0x18) starts a soft reset:
  - the bit reads 1 for 8 clocks and then clears by itself;
  - the mode and timing registers return to their R1 values;
  - the flash control lines return to their R1levels.
- R9: `nand_cle`, `nand_ale` and `nand_ce_n` do not change while either strobe is low.
- R10: A register read returns its data with `cpu_rvalid` one cycle after the accepting edge. Offsets 0x0C, 0x10 and any unmapped offset read 0x00.
- R11: An access is accepted only on a clock edge where `cpu_ready` is high. A request held during a strobe cycle waits SPW+1+HOLD+2 cycles and then completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until accepted |
| cpu_wr | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 5 | Register byte offset |
| cpu_wdata | input | 8 | Write data |
| cpu_ready | output | 1 | High when an access can be accepted |
| cpu_rvalid | output | 1 | Read data valid pulse |
| cpu_rdata | output | 8 | Read data |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 4 | Active-low chip enables, one per device |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_o | output | 8 | Flash data out |
| nand_dq_oe | output | 1 | Flash data output enable |
| nand_dq_i | input | 8 | Flash data in |
| nand_rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
The bench measures strobe and hold lengths at the smallest field values (zero), at mid values and at 15. An off-by-one in either counter shows up as a wrong cycle count. It changes the flash input data right after the read strobe ends: a design that samples late would return the later byte. Data writes with the write-enable bit clear are expected to leave the strobe idle, which catches an ungated engine. The bench also holds a register read against a running strobe and polls the soft reset bit. A port that accepts too early, or a reset that never clears or leaves settings behind, gives a wrong wait count or wrong readback.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  localparam int ADDR_W = 5;
  localparam int REG_W  = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [REG_W-1:0]  reg_t;

  localparam addr_t OFS_DATA   = 5'h00;
  localparam addr_t OFS_MODE   = 5'h04;
  localparam addr_t OFS_STAT   = 5'h08;
  localparam addr_t OFS_TIMING = 5'h14;
  localparam addr_t OFS_RESET  = 5'h18;

  // bits of the mode register that hold state
  localparam reg_t MODE_MASK = 8'h9F;
  localparam int   MODE_WE_BIT = 7;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_HOLD   = 2'd2
  } strobe_state_t;
endpackage

// File: rtl/nbc_sync.sv
module nbc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/nbc_strobe.sv
module nbc_strobe
  import nbc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_wr,
  input  logic             start_rd,
  input  reg_t             wbyte,
  input  logic [CNT_W-1:0] spw,
  input  logic [CNT_W-1:0] hold,
  input  reg_t             dq_i,
  output logic             busy,
  output logic             we_n,
  output logic             re_n,
  output reg_t             dq_o,
  output logic             dq_oe,
  output reg_t             rbyte,
  output logic             rd_done
);
  localparam int CW = CNT_W + 1;

  strobe_state_t   state_q;
  logic [CW-1:0]   cnt_q;
  logic            is_rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      is_rd_q <= 1'b0;
      we_n    <= 1'b1;
      re_n    <= 1'b1;
      dq_o    <= '0;
      dq_oe   <= 1'b0;
      rbyte   <= '0;
      rd_done <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_wr || start_rd) begin
            state_q <= ST_STROBE;
            cnt_q   <= {1'b0, spw};
            is_rd_q <= start_rd;
            we_n    <= ~start_wr;
            re_n    <= ~start_rd;
            dq_oe   <= start_wr;
            if (start_wr) dq_o <= wbyte;
          end
        end
        ST_STROBE: begin
          if (cnt_q == '0) begin
            state_q <= ST_HOLD;
            cnt_q   <= {1'b0, hold} + CW'(1);
            we_n    <= 1'b1;
            re_n    <= 1'b1;
            if (is_rd_q) rbyte <= dq_i;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_HOLD: begin
          if (cnt_q == '0) begin
            state_q <= ST_IDLE;
            dq_oe   <= 1'b0;
            rd_done <= is_rd_q;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);

  // checker: measured strobe length against the latched width field
  logic [CW:0]    low_len_q;
  logic [CNT_W-1:0] spw_lat_q;
  logic           strobe_low;
  assign strobe_low = ~we_n | ~re_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_len_q <= '0;
      spw_lat_q <= '0;
    end else begin
      low_len_q <= strobe_low ? low_len_q + 1'b1 : '0;
      if (!busy && (start_wr || start_rd)) spw_lat_q <= spw;
    end
  end

  p_strobe_width_r3: assert property (@(posedge clk) disable iff (rst)
    (!strobe_low && $past(strobe_low)) |-> (low_len_q == {1'b0, {1'b0, spw_lat_q}} + 1'b1));

  p_single_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));

  p_data_driven_r3: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> dq_oe);
endmodule

// File: rtl/nbc_pins.sv
module nbc_pins #(
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        mode_nxt,
  input  logic              strobe_low,
  output logic              cle,
  output logic              ale,
  output logic [NUM_CS-1:0] ce_n
);
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cle <= 1'b0;
      ale <= 1'b0;
    end else begin
      cle <= mode_nxt[0];
      ale <= mode_nxt[1];
    end
  end

  for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_ce
    always_ff @(posedge clk) begin
      if (rst) ce_n[gi] <= 1'b1;
      else     ce_n[gi] <= ~(mode_nxt[4] && (mode_nxt[2 +: CS_W] == CS_W'(gi)));
    end
  end

  p_pins_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (strobe_low && $past(strobe_low)) |-> $stable({cle, ale, ce_n}));
endmodule

// File: rtl/nbc_regs.sv
module nbc_regs
  import nbc_pkg::*;
#(
  parameter int   RST_CYCLES   = 8,
  parameter reg_t TIMING_RESET = 8'hFF
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  cpu_req,
  input  logic  cpu_wr,
  input  addr_t cpu_addr,
  input  reg_t  cpu_wdata,
  input  logic  eng_busy,
  input  logic  flash_busy,
  output reg_t  mode_nxt,
  output reg_t  timing_q,
  output logic  start_wr,
  output logic  start_rd,
  output logic  reg_rvalid,
  output reg_t  reg_rdata
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  reg_t           mode_q;
  logic [RC_W-1:0] srst_cnt_q;
  logic           srst_active;
  logic           acc;
  logic           is_data;
  reg_t           rd_mux;

  assign acc         = cpu_req && !eng_busy;
  assign is_data     = (cpu_addr == OFS_DATA);
  assign srst_active = (srst_cnt_q != '0);

  assign start_wr = acc && cpu_wr && is_data && mode_q[MODE_WE_BIT] && !srst_active;
  assign start_rd = acc && !cpu_wr && is_data && !srst_active;

  always_comb begin
    mode_nxt = mode_q;
    if (srst_active)
      mode_nxt = '0;
    else if (acc && cpu_wr && cpu_addr == OFS_MODE)
      mode_nxt = cpu_wdata & MODE_MASK;
  end

  always_comb begin
    case (cpu_addr)
      OFS_MODE:   rd_mux = mode_q;
      OFS_STAT:   rd_mux = {flash_busy, 7'b0};
      OFS_TIMING: rd_mux = timing_q;
      OFS_RESET:  rd_mux = {7'b0, srst_active};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      timing_q   <= TIMING_RESET;
      srst_cnt_q <= '0;
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      mode_q     <= mode_nxt;
      reg_rvalid <= acc && !cpu_wr && !start_rd;
      if (acc && !cpu_wr && !start_rd) reg_rdata <= rd_mux;
      if (srst_active) begin
        timing_q   <= TIMING_RESET;
        srst_cnt_q <= srst_cnt_q - RC_W'(1);
      end else if (acc && cpu_wr) begin
        if (cpu_addr == OFS_TIMING) timing_q <= cpu_wdata;
        if (cpu_addr == OFS_RESET && cpu_wdata[0]) srst_cnt_q <= RC_W'(RST_CYCLES);
      end
    end
  end

  p_we_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && cpu_wr && is_data && !mode_q[MODE_WE_BIT]) |=> !eng_busy);

  p_srst_restores_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(srst_active) |-> (mode_q == '0 && timing_q == TIMING_RESET));

  p_reg_read_latency_r10: assert property (@(posedge clk) disable iff (rst)
    (acc && !cpu_wr && !is_data) |=> reg_rvalid);
endmodule

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl
  import nbc_pkg::*;
#(
  parameter int   NUM_CS       = 4,
  parameter int   SYNC_STAGES  = 2,
  parameter int   RST_CYCLES   = 8,
  parameter reg_t TIMING_RESET = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [4:0]        cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [7:0]        cpu_rdata,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic [NUM_CS-1:0] nand_ce_n,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_i,
  input  logic              nand_rb_n
);
  localparam int FIELD_W = REG_W / 2;

  logic eng_busy, rb_sync, start_wr, start_rd, reg_rvalid, rd_done;
  reg_t mode_nxt, timing_q, reg_rdata, rbyte;

  nbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(nand_rb_n), .sync_out(rb_sync)
  );

  nbc_regs #(.RST_CYCLES(RST_CYCLES), .TIMING_RESET(TIMING_RESET)) u_regs (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .eng_busy(eng_busy), .flash_busy(~rb_sync),
    .mode_nxt(mode_nxt), .timing_q(timing_q),
    .start_wr(start_wr), .start_rd(start_rd),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata)
  );

  nbc_strobe #(.CNT_W(FIELD_W)) u_strobe (
    .clk(clk), .rst(rst),
    .start_wr(start_wr), .start_rd(start_rd), .wbyte(cpu_wdata),
    .spw(timing_q[FIELD_W-1:0]), .hold(timing_q[REG_W-1:FIELD_W]),
    .dq_i(nand_dq_i),
    .busy(eng_busy), .we_n(nand_we_n), .re_n(nand_re_n),
    .dq_o(nand_dq_o), .dq_oe(nand_dq_oe), .rbyte(rbyte), .rd_done(rd_done)
  );

  nbc_pins #(.NUM_CS(NUM_CS)) u_pins (
    .clk(clk), .rst(rst), .mode_nxt(mode_nxt[4:0]),
    .strobe_low(~nand_we_n | ~nand_re_n),
    .cle(nand_cle), .ale(nand_ale), .ce_n(nand_ce_n)
  );

  assign cpu_ready  = ~eng_busy;
  assign cpu_rvalid = reg_rvalid | rd_done;
  assign cpu_rdata  = rd_done ? rbyte : reg_rdata;

  p_accept_only_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!cpu_ready && !$past(cpu_ready)) |-> !cpu_rvalid);
endmodule

// File: tb/nand_bus_ctrl_tb_top.sv
module nand_bus_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_req = 1'b0, cpu_wr = 1'b0;
  logic [4:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic       cpu_ready, cpu_rvalid;
  logic [7:0] cpu_rdata;
  logic       nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [3:0] nand_ce_n;
  logic [7:0] nand_dq_o;
  logic [7:0] nand_dq_i = '0;
  logic       nand_rb_n = 1'b1;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_bus_ctrl dut_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
    .cpu_rdata(cpu_rdata), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
    .nand_rb_n(nand_rb_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
    cpu_req = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [7:0] d);
    int n = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    while (!cpu_rvalid && n < 200) begin @(negedge clk); n++; end
    d = cpu_rdata;
  endtask

  // R1
  task automatic t_reset();
    logic [7:0] d;
    check(nand_ce_n == 4'hF, "R1 ce_n", nand_ce_n, 4'hF);
    check({nand_cle, nand_ale, nand_dq_oe} == 3'b000, "R1 latches/oe", {nand_cle, nand_ale, nand_dq_oe}, 0);
    check(nand_we_n && nand_re_n && cpu_ready, "R1 strobes/ready", {nand_we_n, nand_re_n, cpu_ready}, 7);
    reg_rd(5'h04, d); check(d == 8'h00, "R1 mode", d, 8'h00);
    reg_rd(5'h14, d); check(d == 8'hFF, "R1 timing", d, 8'hFF);
  endtask

  // R2 and R10
  task automatic t_mode_pins();
    logic [7:0] d;
    reg_wr(5'h04, 8'h01);
    check(nand_cle && !nand_ale && nand_ce_n == 4'hF, "R2 cle only", {nand_cle, nand_ale, nand_ce_n}, 6'h2F);
    reg_wr(5'h04, 8'h16);
    check(!nand_cle && nand_ale && nand_ce_n == 4'b1101, "R2 ale cs1 ce", {nand_cle, nand_ale, nand_ce_n}, 6'h1D);
    reg_wr(5'h04, 8'h0C);
    check(nand_ce_n == 4'hF, "R2 ce bit clear leaves high", nand_ce_n, 4'hF);
    reg_wr(5'h04, 8'hFF);
    check(nand_ce_n == 4'b0111, "R2 cs3 ce", nand_ce_n, 4'b0111);
    reg_rd(5'h04, d); check(d == 8'h9F, "R2 R10 mode readback", d, 8'h9F);
    reg_rd(5'h0C, d); check(d == 8'h00, "R10 offset 0x0C", d, 0);
    reg_rd(5'h10, d); check(d == 8'h00, "R10 offset 0x10", d, 0);
    reg_rd(5'h1C, d); check(d == 8'h00, "R10 unmapped", d, 0);
  endtask

  // R3, R6, R9
  task automatic t_write(input logic [7:0] tim, input logic [7:0] b);
    int lo = 0, hd = 0;
    logic [7:0] d;
    logic [5:0] pins;
    bit dq_ok = 1'b1, pins_ok = 1'b1;
    reg_wr(5'h14, tim);
    reg_rd(5'h14, d); check(d == tim, "R6 timing readback", d, tim);
    reg_wr(5'h04, 8'h90);
    pins = {nand_cle, nand_ale, nand_ce_n};
    reg_wr(5'h00, b);
    while (!nand_we_n && lo < 100) begin
      if (nand_dq_o != b || !nand_dq_oe) dq_ok = 1'b0;
      if ({nand_cle, nand_ale, nand_ce_n} != pins) pins_ok = 1'b0;
      lo++; @(negedge clk);
    end
    while (nand_dq_oe && hd < 100) begin
      if (nand_dq_o != b) dq_ok = 1'b0;
      hd++; @(negedge clk);
    end
    check(lo == int'(tim[3:0]) + 1, "R3 we_n low length", lo, int'(tim[3:0]) + 1);
    check(hd == int'(tim[7:4]) + 2, "R3 hold length", hd, int'(tim[7:4]) + 2);
    check(dq_ok, "R3 data on bus", nand_dq_o, b);
    check(pins_pins_ok(pins_ok), "R9 pins stable in strobe", {nand_cle, nand_ale, nand_ce_n}, pins);
    check(cpu_ready, "R3 ready after hold", cpu_ready, 1);
  endtask

  function automatic bit pins_pins_ok(input bit v);
    return v;
  endfunction

  // R4
  task automatic t_write_gated();
    bit quiet = 1'b1;
    reg_wr(5'h04, 8'h10);
    reg_wr(5'h00, 8'h5A);
    for (int i = 0; i < 10; i++) begin
      if (!nand_we_n || nand_dq_oe || !cpu_ready) quiet = 1'b0;
      @(negedge clk);
    end
    check(quiet, "R4 gated write ignored", {nand_we_n, nand_dq_oe, cpu_ready}, 3'b101);
  endtask

  // R5
  task automatic t_read(input logic [7:0] tim, input logic [7:0] b);
    int lo = 0, hd = 0;
    reg_wr(5'h14, tim);
    nand_dq_i = b;
    @(negedge clk);
    cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = 5'h00;
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    while (!nand_re_n && lo < 100) begin lo++; @(negedge clk); end
    nand_dq_i = ~b;
    while (!cpu_ready && hd < 100) begin hd++; @(negedge clk); end
    check(lo == int'(tim[3:0]) + 1, "R5 re_n low length", lo, int'(tim[3:0]) + 1);
    check(hd == int'(tim[7:4]) + 2, "R5 read hold length", hd, int'(tim[7:4]) + 2);
    check(cpu_rvalid && cpu_rdata == b, "R5 captured byte", cpu_rdata, b);
  endtask

  // R11
  task automatic t_stall();
    int waitc = 0;
    reg_wr(5'h14, 8'h12);
    reg_wr(5'h04, 8'h80);
    reg_wr(5'h00, 8'hC3);
    cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = 5'h14;
    while (!cpu_ready && waitc < 100) begin waitc++; @(negedge clk); end
    @(negedge clk);
    cpu_req = 1'b0;
    check(waitc == 6, "R11 stall cycles", waitc, 6);
    check(cpu_rvalid && cpu_rdata == 8'h12, "R11 stalled read data", cpu_rdata, 8'h12);
  endtask

  // R7
  task automatic t_status();
    logic [7:0] d;
    nand_rb_n = 1'b0;
    repeat (4) @(negedge clk);
    reg_rd(5'h08, d); check(d == 8'h80, "R7 busy shown", d, 8'h80);
    nand_rb_n = 1'b1;
    repeat (4) @(negedge clk);
    reg_rd(5'h08, d); check(d == 8'h00, "R7 ready shown", d, 8'h00);
  endtask

  // R8
  task automatic t_srst();
    logic [7:0] d;
    int polls = 0;
    reg_wr(5'h14, 8'h35);
    reg_wr(5'h04, 8'h9D);
    check(nand_ce_n == 4'b0111 && nand_cle, "R8 setup pins", {nand_cle, nand_ce_n}, 5'h17);
    reg_wr(5'h18, 8'h01);
    reg_rd(5'h18, d); check(d == 8'h01, "R8 reset bit set", d, 1);
    while (d[0] && polls < 50) begin reg_rd(5'h18, d); polls++; end
    check(d == 8'h00 && polls < 8, "R8 reset self-clears", polls, 8);
    reg_rd(5'h04, d); check(d == 8'h00, "R8 mode restored", d, 0);
    reg_rd(5'h14, d); check(d == 8'hFF, "R8 timing restored", d, 8'hFF);
    check(nand_ce_n == 4'hF && !nand_cle, "R8 pins restored", {nand_cle, nand_ce_n}, 5'h0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mode_pins();
    t_write(8'h35, 8'hA5);
    t_write(8'h00, 8'h3C);
    t_write(8'hFF, 8'h81);
    t_write_gated();
    t_read(8'h21, 8'h6E);
    t_read(8'h00, 8'h17);
    t_stall();
    t_status();
    t_srst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule